// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block pulls constant data out of a word-wide program memory and hands it back as two bytes. Software first writes a page pointer and an offset pointer through a small register port. A command then starts a table read. A normal read forms the word address from the page pointer and the offset. A last-page read takes the offset within the topmost page of the memory and disregards the page pointer. The low byte of the fetched word is written through a data-memory write port to the destination register named by the command. The high byte, zero-padded above the program word width, is loaded into a latch that software can read and also overwrite.

A basic command always writes into sector 0 of data memory. An extended command carries a sector number to the write port. The program memory is an internal array that is filled through its own write port. Every read takes two cycles. A controller with three states sequences it. IDLE waits for a command and moves to FETCH when one is accepted. FETCH reads the addressed word and always moves to WRITE. WRITE drives the data-memory write, loads the high-byte latch, pulses done, and always moves back to IDLE.

Top module: `pmtab_reader`

## Requirements
- R1: After reset the page pointer, the offset pointer and the high-byte latch read 0, and busy, done and dm_we are low.
- R2: While idle, a register write with reg_sel 0 sets the offset pointer and reg_sel 1 sets the page pointer. reg_sel 2 sets the high-byte latch, which keeps only WORD_W-8 bits; bits at and above WORD_W-8 read 0. reg_sel 3 changes nothing. The new value shows on the outputs in the next cycle.
- R3: A normal read (cmd_last 0) fetches the word at {page pointer, offset pointer}. Page pointer bits at and above ADDR_W-8 are ignored, so the address wraps inside the memory.
- R4: A last-page read (cmd_last 1) fetches the word at {all ones, offset pointer} whatever the page pointer holds. With ADDR_W 12, an offset of 06h fetches word F06h.
- R5: On completion, dm_we is high for one cycle with dm_addr equal to the command's destination and dm_wdata equal to bits 7:0 of the fetched word.
- R6: In the cycle after done, hi_latch holds bits WORD_W-1:8 of the fetched word, with the bits above them reading 0.
- R7: A command is accepted in a cycle where cmd_valid is high and busy is low. busy is then high for exactly the next two cycles, and done and dm_we are high in the second of them only.
- R8: While busy, cmd_valid and register writes are ignored. No extra read starts, and the pointers and latch are not changed by them.
- R9: A basic command (cmd_ext 0) writes with dm_sect 0 whatever cmd_sect holds. An extended command (cmd_ext 1) writes with dm_sect equal to the cmd_sect it was issued with.
- R10: Word address 0 can be fetched like any other word.
- R11: A software write to the latch between two reads replaces its content, and the next read replaces it again.
- R12: A command and a pointer write presented in the same idle cycle both take effect, and the command uses the pointer values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 offset, 1 page, 2 latch, 3 none |
| reg_wdata | input | 8 | Register write data |
| page_ptr | output | 8 | Page pointer value |
| off_ptr | output | 8 | Offset pointer value |
| hi_latch | output | 8 | High-byte latch, zero-padded |
| cmd_valid | input | 1 | Start a table read |
| cmd_last | input | 1 | 1 selects a last-page read |
| cmd_ext | input | 1 | 1 selects an extended command that carries a sector |
| cmd_sect | input | SECT_W | Destination sector for extended commands |
| cmd_dest | input | DEST_W | Destination register address |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| dm_we | output | 1 | Data-memory write enable |
| dm_sect | output | SECT_W | Data-memory sector |
| dm_addr | output | DEST_W | Data-memory register address |
| dm_wdata | output | 8 | Low byte of the fetched word |
| pm_wr_en | input | 1 | Program memory load strobe |
| pm_wr_addr | input | ADDR_W | Program memory load address |
| pm_wr_data | input | WORD_W | Program memory load word |

## Verification
The bench builds the block with ADDR_W 12 and WORD_W 15, which gives a 4K-word memory and a 7-bit high byte. With these values the last page starts at F00h, so the offset-06h case lands on F06h and can be checked exactly. The 4-bit page field also lets page values above 0Fh show the wrap. Because the words are 15 bits wide, bit 7 of the latch must read 0 both after a fetch and after a software write of FFh.

// File: rtl/pmtab_pkg.sv
package pmtab_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } pmtab_state_e;

    localparam logic [1:0] SEL_OFF  = 2'd0;
    localparam logic [1:0] SEL_PAGE = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;
endpackage

// File: rtl/pmtab_ptrs.sv
module pmtab_ptrs
    import pmtab_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] page_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [ADDR_W-1:0] norm_addr,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int PAGE_BITS = ADDR_W - OFF_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_PAGE) page_q <= wdata;
            if (sel == SEL_OFF)  off_q  <= wdata[OFF_W-1:0];
        end
    end

    // Only the page bits that fit the memory depth take part.
    always_comb begin
        norm_addr = {page_q[PAGE_BITS-1:0], off_q};
        last_addr = {{PAGE_BITS{1'b1}}, off_q};
    end
endmodule

// File: rtl/pmtab_store.sv
module pmtab_store #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 15
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= words[rd_addr];
    end
endmodule

// File: rtl/pmtab_fsm.sv
module pmtab_fsm
    import pmtab_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 15,
    parameter int DEST_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic                     cmd_last,
    input  logic                     cmd_ext,
    input  logic [SECT_W-1:0]        cmd_sect,
    input  logic [DEST_W-1:0]        cmd_dest,
    input  logic [ADDR_W-1:0]        norm_addr,
    input  logic [ADDR_W-1:0]        last_addr,
    output logic                     rd_en,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [WORD_W-1:0]        rd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     dm_we,
    output logic [SECT_W-1:0]        dm_sect,
    output logic [DEST_W-1:0]        dm_addr,
    output logic [BYTE_W-1:0]        dm_wdata,
    output logic                     hi_load,
    output logic [WORD_W-BYTE_W-1:0] hi_bits
);
    pmtab_state_e state, state_nx;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DEST_W-1:0] dest_q;
    logic [SECT_W-1:0] sect_q;
    logic              ext_q;

    assign accept = (state == ST_IDLE) && cmd_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dest_q <= '0;
            sect_q <= '0;
            ext_q  <= 1'b0;
        end else if (accept) begin
            addr_q <= cmd_last ? last_addr : norm_addr;
            dest_q <= cmd_dest;
            sect_q <= cmd_ext ? cmd_sect : '0;
            ext_q  <= cmd_ext;
        end
    end

    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        dm_we    = 1'b0;
        hi_load  = 1'b0;
        rd_en    = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FETCH: begin
                busy  = 1'b1;
                rd_en = 1'b1;
            end
            ST_WRITE: begin
                busy    = 1'b1;
                done    = 1'b1;
                dm_we   = 1'b1;
                hi_load = 1'b1;
            end
            default:  ;
        endcase
        rd_addr  = addr_q;
        dm_addr  = dest_q;
        dm_sect  = sect_q;
        dm_wdata = rd_data[BYTE_W-1:0];
        hi_bits  = rd_data[WORD_W-1:BYTE_W];
    end

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && !done));
    // R7
    done_prior_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R4
    last_page_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_last) |=> (&rd_addr[ADDR_W-1:OFF_W]));
    // R9
    basic_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_we && !ext_q) |-> (dm_sect == '0));
endmodule

// File: rtl/pmtab_reader.sv
module pmtab_reader
    import pmtab_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 15,
    parameter int DEST_W = 8,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        page_ptr,
    output logic [7:0]        off_ptr,
    output logic [7:0]        hi_latch,
    input  logic              cmd_valid,
    input  logic              cmd_last,
    input  logic              cmd_ext,
    input  logic [SECT_W-1:0] cmd_sect,
    input  logic [DEST_W-1:0] cmd_dest,
    output logic              busy,
    output logic              done,
    output logic              dm_we,
    output logic [SECT_W-1:0] dm_sect,
    output logic [DEST_W-1:0] dm_addr,
    output logic [7:0]        dm_wdata,
    input  logic              pm_wr_en,
    input  logic [ADDR_W-1:0] pm_wr_addr,
    input  logic [WORD_W-1:0] pm_wr_data
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic              reg_wr_ok;
    logic [ADDR_W-1:0] norm_addr, last_addr, rd_addr;
    logic              rd_en, hi_load;
    logic [WORD_W-1:0] rd_data;
    logic [HI_W-1:0]   hi_bits, hi_q;

    assign reg_wr_ok = reg_wr_en && !busy;

    pmtab_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_ok),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .page_q    (page_ptr),
        .off_q     (off_ptr),
        .norm_addr (norm_addr),
        .last_addr (last_addr)
    );

    pmtab_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (pm_wr_en),
        .wr_addr (pm_wr_addr),
        .wr_data (pm_wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pmtab_fsm #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEST_W (DEST_W),
        .SECT_W (SECT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_last  (cmd_last),
        .cmd_ext   (cmd_ext),
        .cmd_sect  (cmd_sect),
        .cmd_dest  (cmd_dest),
        .norm_addr (norm_addr),
        .last_addr (last_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done),
        .dm_we     (dm_we),
        .dm_sect   (dm_sect),
        .dm_addr   (dm_addr),
        .dm_wdata  (dm_wdata),
        .hi_load   (hi_load),
        .hi_bits   (hi_bits)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                hi_q <= '0;
        else if (hi_load)                          hi_q <= hi_bits;
        else if (reg_wr_ok && reg_sel == SEL_HI)   hi_q <= reg_wdata[HI_W-1:0];
    end

    generate
        if (HI_W < BYTE_W) begin : g_pad
            assign hi_latch = {{(BYTE_W-HI_W){1'b0}}, hi_q};
        end else begin : g_full
            assign hi_latch = hi_q;
        end
    endgenerate

    // R8
    busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en) |=> ($stable(page_ptr) && $stable(off_ptr)));
    // R6
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (hi_q == $past(hi_bits)));
endmodule

// File: tb/pmtab_reader_tb.sv
module pmtab_reader_tb;
    localparam int AW = 12;
    localparam int WW = 15;
    localparam int DW = 8;
    localparam int SW = 2;
    localparam int DEPTH = 1 << AW;
    localparam int PMASK = (1 << (AW - 8)) - 1;
    localparam int LAST_BASE = DEPTH - 256;
    localparam int HMASK = (1 << (WW - 8)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    page_ptr, off_ptr, hi_latch;
    logic          cmd_valid = 1'b0, cmd_last = 1'b0, cmd_ext = 1'b0;
    logic [SW-1:0] cmd_sect = '0;
    logic [DW-1:0] cmd_dest = '0;
    logic          busy, done, dm_we;
    logic [SW-1:0] dm_sect;
    logic [DW-1:0] dm_addr;
    logic [7:0]    dm_wdata;
    logic          pm_wr_en = 1'b0;
    logic [AW-1:0] pm_wr_addr = '0;
    logic [WW-1:0] pm_wr_data = '0;

    always #4 clk = ~clk;

    pmtab_reader #(.ADDR_W(AW), .WORD_W(WW), .DEST_W(DW), .SECT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .page_ptr(page_ptr), .off_ptr(off_ptr), .hi_latch(hi_latch),
        .cmd_valid(cmd_valid), .cmd_last(cmd_last), .cmd_ext(cmd_ext),
        .cmd_sect(cmd_sect), .cmd_dest(cmd_dest),
        .busy(busy), .done(done), .dm_we(dm_we), .dm_sect(dm_sect),
        .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .pm_wr_en(pm_wr_en), .pm_wr_addr(pm_wr_addr), .pm_wr_data(pm_wr_data)
    );

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    int mem_m [DEPTH];
    int m_st = 0, m_addr = 0, m_dest = 0, m_sect = 0, m_word = 0;
    int m_page = 0, m_off = 0, m_latch = 0;

    function automatic int pattern(input int a);
        return (a * 73 + 19) & 32'h7FFF;
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        int nxt;
        nxt = m_st;
        if (m_st == 0) begin
            if (cmd_valid) begin
                m_addr = cmd_last ? (LAST_BASE + m_off) : (((m_page & PMASK) << 8) + m_off);
                m_dest = cmd_dest;
                m_sect = cmd_ext ? int'(cmd_sect) : 0;
                nxt = 1;
            end
            if (reg_wr_en) begin
                if (reg_sel == 2'd0) m_off = reg_wdata;
                else if (reg_sel == 2'd1) m_page = reg_wdata;
                else if (reg_sel == 2'd2) m_latch = reg_wdata & HMASK;
            end
        end else if (m_st == 1) begin
            m_word = mem_m[m_addr];
            nxt = 2;
        end else begin
            m_latch = (m_word >> 8) & HMASK;
            nxt = 0;
        end
        if (pm_wr_en) mem_m[pm_wr_addr] = pm_wr_data;
        m_st = nxt;
    endtask

    task automatic compare(input string req);
        cmp(req, "busy", busy, m_st != 0);
        cmp(req, "done", done, m_st == 2);
        cmp(req, "dm_we", dm_we, m_st == 2);
        cmp(req, "page_ptr", page_ptr, m_page);
        cmp(req, "off_ptr", off_ptr, m_off);
        cmp(req, "hi_latch", hi_latch, m_latch);
        if (m_st == 2) begin
            cmp(req, "dm_addr", dm_addr, m_dest);
            cmp(req, "dm_sect", dm_sect, m_sect);
            cmp(req, "dm_wdata", dm_wdata, m_word & 255);
        end
    endtask

    task automatic step(input string req);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(req);
        reg_wr_en = 1'b0; cmd_valid = 1'b0; cmd_last = 1'b0; cmd_ext = 1'b0;
        cmd_sect = '0; pm_wr_en = 1'b0;
    endtask

    task automatic wreg(input int sel, input int val, input string req);
        reg_wr_en = 1'b1; reg_sel = 2'(sel); reg_wdata = 8'(val);
        step(req);
    endtask

    task automatic issue(input bit last, input bit ext, input int sect, input int dest, input string req);
        cmd_valid = 1'b1; cmd_last = last; cmd_ext = ext;
        cmd_sect = SW'(sect); cmd_dest = DW'(dest);
        step(req);
        step(req);
        step(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        for (int a = 0; a < DEPTH; a++) begin
            pm_wr_en = 1'b1; pm_wr_addr = AW'(a); pm_wr_data = WW'(pattern(a));
            step("R1");
        end

        // R2: register writes and unused select
        wreg(1, 8'h03, "R2");
        wreg(0, 8'h10, "R2");
        wreg(2, 8'hFF, "R2");
        cmp("R2", "latch_pad", hi_latch, 8'h7F);
        wreg(3, 8'hA5, "R2");

        // R3 R5 R7: normal read
        cmd_valid = 1'b1; cmd_dest = 8'h21;
        step("R7");
        cmp("R7", "busy_first", busy, 1);
        step("R7");
        cmp("R5", "wdata_310", dm_wdata, pattern(12'h310) & 255);
        step("R6");
        cmp("R6", "latch_310", hi_latch, (pattern(12'h310) >> 8) & HMASK);

        // R3: page bits beyond depth wrap
        wreg(1, 8'hF3, "R3");
        issue(1'b0, 1'b0, 0, 8'h22, "R3");

        // R4: last-page read at offset 06h
        wreg(1, 8'h05, "R4");
        wreg(0, 8'h06, "R4");
        cmd_valid = 1'b1; cmd_last = 1'b1; cmd_dest = 8'h40;
        step("R4");
        step("R4");
        cmp("R4", "word_F06_lo", dm_wdata, pattern(12'hF06) & 255);
        step("R4");

        // R9: sectors
        issue(1'b0, 1'b1, 2, 8'h11, "R9");
        issue(1'b1, 1'b1, 3, 8'h12, "R9");
        issue(1'b0, 1'b0, 3, 8'h13, "R9");

        // R8: commands and writes while busy
        cmd_valid = 1'b1; cmd_dest = 8'h50;
        step("R8");
        cmd_valid = 1'b1; reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'hEE;
        step("R8");
        cmd_valid = 1'b1; reg_wr_en = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h11;
        step("R8");
        cmp("R8", "off_kept", off_ptr, 8'h06);
        step("R8");

        // R10: address zero
        wreg(1, 8'h00, "R10");
        wreg(0, 8'h00, "R10");
        issue(1'b0, 1'b0, 0, 8'h01, "R10");
        cmp("R10", "latch_000", hi_latch, (pattern(0) >> 8) & HMASK);

        // R11: software overwrite of the latch
        wreg(2, 8'h2A, "R11");
        cmp("R11", "latch_sw", hi_latch, 8'h2A);
        issue(1'b0, 1'b0, 0, 8'h02, "R11");

        // R12: command together with pointer write
        wreg(1, 8'h07, "R12");
        wreg(0, 8'h80, "R12");
        cmd_valid = 1'b1; cmd_dest = 8'h33;
        reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h81;
        step("R12");
        step("R12");
        cmp("R12", "old_ptr_word", dm_wdata, pattern(12'h780) & 255);
        step("R12");
        cmp("R12", "off_new", off_ptr, 8'h81);

        // R7: back-to-back commands held valid
        for (int k = 0; k < 9; k++) begin
            cmd_valid = 1'b1; cmd_last = k[0]; cmd_dest = DW'(k);
            step("R7");
        end
        step("R7");
        step("R7");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule